// File: doc/BRIEF.md
# Quarter-Phase Memory Strobe Generator

This block produces the active-low strobes for an external memory bank: one chip select, four byte selects and one general-purpose line. A control word sets the level of each strobe for each quarter of a bus clock cycle. Each quarter boundary falls on an edge of one of two phase clocks. In this design the four quarter boundaries are four consecutive edges of one clock running at four times the bus rate, so all logic stays in one clock domain.

The byte selects are also gated by the bank's port width, the transfer size and the two low address bits. A lane is driven only when the access actually touches that byte on that port. The general-purpose line changes once per bus cycle, at the first quarter boundary, under a 2-bit code. The code can assert the line, negate it, drive a supplied default level, or hold the line. The word source and any sequencing through stored words sit outside this block. All inputs are plain level controls with no handshake. A new word applies at the next quarter boundary.

Top module: `mem_strobe_gen`

## Requirements
- R1: While `rst` is high, every strobe output is 1 (negated). The first clock edge after `rst` falls is the phase-1 boundary.
- R2: A 2-bit phase counter steps 1,2,3,4,1,… on every clock edge. The edge at phase k applies the phase-k settings. The result is visible on the outputs after that edge.
- R3: At the phase-k edge, `chip_sel_n` takes the value of `cs_wave[k-1]`. A 0 asserts the strobe (drives it low) and a 1 negates it.
- R4: At the phase-k edge, `byte_sel_n[i]` becomes 0 only if `bsel_wave[k-1]` is 0 and lane i is touched by the access. Untouched lanes become 1.
- R5: The transfer size code `xfer_sz` gives the byte count: 00 means 4 bytes, and any other code gives that many bytes. Let W be the port width in bytes. The access starts at offset s = `addr_lo` mod W and touches lanes s through min(s+n, W)-1. Bit i of `byte_sel_n` is the byte at offset i.
- R6: `port_sz` 00 is a 32-bit port (lanes 0–3). Code 01 is a 16-bit port (lanes 0–1 only). Code 10 is an 8-bit port (lane 0 only). Code 11 is treated as 32-bit.
- R7: At the phase-1 edge, `gp_code` 10 drives `gp_line_n` to 0 and code 11 drives it to 1.
- R8: At the phase-1 edge, `gp_code` 00 drives `gp_line_n` to the level of `gp_dflt`.
- R9: At the phase-1 edge, `gp_code` 01 leaves `gp_line_n` at its previous value.
- R10: `gp_line_n` does not change at the phase-2, phase-3 or phase-4 edges, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Quarter-phase clock, four edges per bus cycle |
| rst | input | 1 | Synchronous reset, active high |
| cs_wave | input | 4 | Chip-select level for each phase (bit k-1 applies to phase k) |
| bsel_wave | input | 4 | Byte-select level for each phase (bit k-1 applies to phase k) |
| gp_code | input | 2 | General-line code applied at the phase-1 edge |
| gp_dflt | input | 1 | Level driven on the general line when the code is 00 |
| port_sz | input | 2 | Port width of the selected bank |
| xfer_sz | input | 2 | Transfer size code of the current access |
| addr_lo | input | 2 | Two low address bits of the current access |
| chip_sel_n | output | 1 | Chip select, active low |
| byte_sel_n | output | 4 | Byte selects, active low, bit i is byte offset i |
| gp_line_n | output | 1 | General-purpose line |

## Verification
The general-line update and the chip-select and byte-select updates all fall on the same phase-1 edge. At that edge one registered write depends on the line's previous value while the others load fresh levels. The bench gives the general-line code a new random value together with the waveform bits and the lane qualifiers on every edge, so the hold, default, assert and negate codes each meet a phase-1 edge on which the byte selects also change. A reference model tracks the quarter count and the held line level and judges all three outputs separately after every edge. The same model confirms that a new code arriving on a phase-2, phase-3 or phase-4 edge leaves the line untouched.

// File: rtl/mem_strobe_pkg.sv
package mem_strobe_pkg;

  typedef enum logic [1:0] {
    PORT_W32 = 2'b00,
    PORT_W16 = 2'b01,
    PORT_W8  = 2'b10,
    PORT_RSV = 2'b11
  } port_size_e;

  typedef enum logic [1:0] {
    GP_USE_DFLT = 2'b00,
    GP_KEEP     = 2'b01,
    GP_DRIVE_LO = 2'b10,
    GP_DRIVE_HI = 2'b11
  } gp_code_e;

  // Bytes carried by a port of the given width code (reserved code -> full width)
  function automatic int unsigned port_bytes(input logic [1:0] ps, input int unsigned full);
    case (port_size_e'(ps))
      PORT_W16: port_bytes = (full >= 2) ? 2 : full;
      PORT_W8:  port_bytes = 1;
      default:  port_bytes = full;
    endcase
  endfunction

endpackage

// File: rtl/mem_strobe_phase.sv
module mem_strobe_phase #(
  parameter int NUM_PHASES = 4,
  localparam int PH_W = $clog2(NUM_PHASES)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] phase,
  output logic            first_ph
);
  localparam logic [PH_W-1:0] LAST = PH_W'(NUM_PHASES - 1);

  always_ff @(posedge clk) begin
    if (rst)                phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + 1'b1;
  end

  assign first_ph = (phase == '0);
endmodule

// File: rtl/mem_strobe_lanes.sv
module mem_strobe_lanes
  import mem_strobe_pkg::*;
#(
  parameter int NUM_LANES = 4,
  localparam int SZ_W = $clog2(NUM_LANES)
) (
  input  logic [1:0]           port_sz,
  input  logic [SZ_W-1:0]      xfer_sz,
  input  logic [SZ_W-1:0]      addr_lo,
  output logic [NUM_LANES-1:0] lane_en
);
  int unsigned width_b;
  int unsigned start_b;
  int unsigned count_b;

  always_comb begin
    width_b = port_bytes(port_sz, NUM_LANES);
    start_b = 32'(addr_lo) & (width_b - 1);
    count_b = (xfer_sz == '0) ? NUM_LANES : 32'(xfer_sz);
  end

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    assign lane_en[i] = (i < width_b) && (i >= start_b) && (i < start_b + count_b);
  end
endmodule

// File: rtl/mem_strobe_outs.sv
module mem_strobe_outs #(
  parameter int NUM_PHASES = 4,
  parameter int NUM_LANES  = 4,
  localparam int PH_W = $clog2(NUM_PHASES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [PH_W-1:0]       phase,
  input  logic [NUM_PHASES-1:0] cs_wave,
  input  logic [NUM_PHASES-1:0] bsel_wave,
  input  logic [NUM_LANES-1:0]  lane_en,
  output logic                  chip_sel_n,
  output logic [NUM_LANES-1:0]  byte_sel_n
);
  logic cs_lvl;
  logic bs_lvl;

  assign cs_lvl = cs_wave[phase];
  assign bs_lvl = bsel_wave[phase];

  always_ff @(posedge clk) begin
    if (rst) chip_sel_n <= 1'b1;
    else     chip_sel_n <= cs_lvl;
  end

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_bs
    always_ff @(posedge clk) begin
      if (rst) byte_sel_n[i] <= 1'b1;
      else     byte_sel_n[i] <= bs_lvl | ~lane_en[i];
    end
  end
endmodule

// File: rtl/mem_strobe_gpl.sv
module mem_strobe_gpl
  import mem_strobe_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       first_ph,
  input  logic [1:0] gp_code,
  input  logic       gp_dflt,
  output logic       gp_line_n
);
  always_ff @(posedge clk) begin
    if (rst) gp_line_n <= 1'b1;
    else if (first_ph) begin
      case (gp_code_e'(gp_code))
        GP_DRIVE_LO: gp_line_n <= 1'b0;
        GP_DRIVE_HI: gp_line_n <= 1'b1;
        GP_USE_DFLT: gp_line_n <= gp_dflt;
        default:     gp_line_n <= gp_line_n;
      endcase
    end
  end
endmodule

// File: rtl/mem_strobe_gen.sv
module mem_strobe_gen #(
  parameter int NUM_PHASES = 4,
  parameter int NUM_LANES  = 4,
  localparam int PH_W = $clog2(NUM_PHASES),
  localparam int SZ_W = $clog2(NUM_LANES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_PHASES-1:0] cs_wave,
  input  logic [NUM_PHASES-1:0] bsel_wave,
  input  logic [1:0]            gp_code,
  input  logic                  gp_dflt,
  input  logic [1:0]            port_sz,
  input  logic [SZ_W-1:0]       xfer_sz,
  input  logic [SZ_W-1:0]       addr_lo,
  output logic                  chip_sel_n,
  output logic [NUM_LANES-1:0]  byte_sel_n,
  output logic                  gp_line_n
);
  logic [PH_W-1:0]      phase;
  logic                 first_ph;
  logic [NUM_LANES-1:0] lane_en;

  mem_strobe_phase #(.NUM_PHASES(NUM_PHASES)) u_phase (
    .clk(clk), .rst(rst), .phase(phase), .first_ph(first_ph)
  );

  mem_strobe_lanes #(.NUM_LANES(NUM_LANES)) u_lanes (
    .port_sz(port_sz), .xfer_sz(xfer_sz), .addr_lo(addr_lo), .lane_en(lane_en)
  );

  mem_strobe_outs #(.NUM_PHASES(NUM_PHASES), .NUM_LANES(NUM_LANES)) u_outs (
    .clk(clk), .rst(rst), .phase(phase), .cs_wave(cs_wave), .bsel_wave(bsel_wave),
    .lane_en(lane_en), .chip_sel_n(chip_sel_n), .byte_sel_n(byte_sel_n)
  );

  mem_strobe_gpl u_gpl (
    .clk(clk), .rst(rst), .first_ph(first_ph), .gp_code(gp_code),
    .gp_dflt(gp_dflt), .gp_line_n(gp_line_n)
  );
endmodule

// File: rtl/mem_strobe_gen_chk.sv
module mem_strobe_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] phase,
  input logic [3:0] cs_wave,
  input logic [3:0] bsel_wave,
  input logic [1:0] gp_code,
  input logic [1:0] port_sz,
  input logic [1:0] xfer_sz,
  input logic       chip_sel_n,
  input logic [3:0] byte_sel_n,
  input logic       gp_line_n
);
  AST_RESET_NEG: assert property (@(posedge clk) rst |=> (chip_sel_n && (&byte_sel_n) && gp_line_n)); // R1
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> (phase == 2'($past(phase) + 2'd1))); // R2
  AST_CS_NEG: assert property (@(posedge clk) disable iff (rst) (cs_wave == 4'hF) |=> chip_sel_n); // R3
  AST_BS_OFF: assert property (@(posedge clk) disable iff (rst) (bsel_wave == 4'hF) |=> (&byte_sel_n)); // R4
  AST_BS_BYTE: assert property (@(posedge clk) disable iff (rst) (xfer_sz == 2'd1) |=> $onehot0(~byte_sel_n)); // R5
  AST_BS_NARROW: assert property (@(posedge clk) disable iff (rst) (port_sz == 2'b10) |=> (&byte_sel_n[3:1])); // R6
  AST_GP_HOLD: assert property (@(posedge clk) disable iff (rst) (phase == 2'd0 && gp_code == 2'b01) |=> $stable(gp_line_n)); // R9
  AST_GP_QUIET: assert property (@(posedge clk) disable iff (rst) (phase != 2'd0) |=> $stable(gp_line_n)); // R10
endmodule

bind mem_strobe_gen mem_strobe_gen_chk u_chk (
  .clk(clk), .rst(rst), .phase(phase), .cs_wave(cs_wave), .bsel_wave(bsel_wave),
  .gp_code(gp_code), .port_sz(port_sz), .xfer_sz(xfer_sz),
  .chip_sel_n(chip_sel_n), .byte_sel_n(byte_sel_n), .gp_line_n(gp_line_n)
);

// File: tb/mem_strobe_gen_bench.sv
`timescale 1ns/1ps
module mem_strobe_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] cs_wave = 4'hF;
  logic [3:0] bsel_wave = 4'hF;
  logic [1:0] gp_code = 2'b01;
  logic       gp_dflt = 1'b1;
  logic [1:0] port_sz = 2'b00;
  logic [1:0] xfer_sz = 2'b00;
  logic [1:0] addr_lo = 2'b00;
  logic       chip_sel_n;
  logic [3:0] byte_sel_n;
  logic       gp_line_n;

  int checks = 0;
  int errors = 0;
  int ph = 0;           // 0..3 means phase 1..4
  logic gp_model = 1'b1;
  bit done = 0;

  always #4 clk = ~clk;

  mem_strobe_gen u_mem_strobe_gen (
    .clk(clk), .rst(rst), .cs_wave(cs_wave), .bsel_wave(bsel_wave),
    .gp_code(gp_code), .gp_dflt(gp_dflt), .port_sz(port_sz), .xfer_sz(xfer_sz),
    .addr_lo(addr_lo), .chip_sel_n(chip_sel_n), .byte_sel_n(byte_sel_n),
    .gp_line_n(gp_line_n)
  );

  function automatic logic [3:0] ref_lanes(input logic [1:0] ps, input logic [1:0] xs, input logic [1:0] a);
    int w, s, n;
    logic [3:0] m;
    w = (ps == 2'b01) ? 2 : (ps == 2'b10) ? 1 : 4;
    s = int'(a) % w;
    n = (xs == 2'b00) ? 4 : int'(xs);
    m = 4'b0000;
    for (int k = 0; k < 4; k++)
      if (k < w && k >= s && k < s + n) m[k] = 1'b1;
    return m;
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b (phase %0d)", tag, act, exp, ph + 1);
    end
  endtask

  // Apply current inputs across one edge, then judge the outputs.
  task automatic step();
    logic       e_cs;
    logic [3:0] e_bs;
    string      gtag;
    e_cs = cs_wave[ph];
    e_bs = {4{bsel_wave[ph]}} | ~ref_lanes(port_sz, xfer_sz, addr_lo);
    gtag = "R10";
    if (ph == 0) begin
      case (gp_code)
        2'b10: begin gp_model = 1'b0; gtag = "R7"; end
        2'b11: begin gp_model = 1'b1; gtag = "R7"; end
        2'b00: begin gp_model = gp_dflt; gtag = "R8"; end
        default: gtag = "R9";
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    check("R2 R3 chip select", {3'b0, chip_sel_n}, {3'b0, e_cs});
    check("R4 R5 R6 byte selects", byte_sel_n, e_bs);
    check({gtag, " general line"}, {3'b0, gp_line_n}, {3'b0, gp_model});
    ph = (ph + 1) % 4;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1: strobes negated while reset is held, even with asserting inputs
    cs_wave = 4'h0; bsel_wave = 4'h0; gp_code = 2'b10;
    @(negedge clk);
    check("R1 reset chip select", {3'b0, chip_sel_n}, 4'b0001);
    check("R1 reset byte selects", byte_sel_n, 4'hF);
    check("R1 reset general line", {3'b0, gp_line_n}, 4'b0001);
    rst = 1'b0;

    // Directed: every port width, size, offset across all four phases
    for (int p = 0; p < 4; p++)
      for (int x = 0; x < 4; x++)
        for (int a = 0; a < 4; a++)
          for (int q = 0; q < 4; q++) begin
            port_sz = 2'(p); xfer_sz = 2'(x); addr_lo = 2'(a);
            cs_wave = 4'(4'b0101 ^ (q * 3));
            bsel_wave = 4'(~(4'b0001 << ph));
            gp_code = 2'(q); gp_dflt = a[0];
            step();
          end

    // Directed: hold code after a drive-low code at phase 1 (R9)
    while (ph != 0) step();
    gp_code = 2'b10; step();
    gp_code = 2'b11; step(); step(); step();
    gp_code = 2'b01; step();

    // Constrained random: codes and qualifiers change on every edge
    for (int i = 0; i < 3000; i++) begin
      cs_wave   = 4'($urandom);
      bsel_wave = 4'($urandom);
      gp_code   = 2'($urandom);
      gp_dflt   = 1'($urandom);
      port_sz   = 2'($urandom);
      xfer_sz   = 2'($urandom);
      addr_lo   = 2'($urandom);
      step();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule